// File: doc/BRIEF.md
# Speculative UART Register Window

This block sits on the load/store path of an out-of-order core and presents three word addresses that reach a byte-wide UART: a transmit byte register, a receive byte register and a two-bit status register. The core sends loads and stores to it while they are still speculative. The block answers each one a cycle later. Any side effect the access has (a consumed receive byte, a claimed transmitter) is first recorded only in a speculative copy of the status. The access is also put into an ordered queue together with its reorder-buffer tag.

The UART itself is affected only when the oldest queue entry retires. A retiring transmit entry loads the byte into the transmitter and pulses its start strobe. A retiring receive entry frees the receive register for the next byte. The architectural status copy follows these commits and the UART's own ready and done inputs. The speculative copy is reloaded from it through a toggle-flag handshake. A pipeline flush drops every unretired entry and realigns the speculative copy at once.

Top module: `spec_uart_regs`

## Requirements
- R1: After reset both status copies are 0, the queue is empty (`headValid` 0), `reqReady` is 1, and `rspValid` and `txStart` are 0.
- R2: Every accepted request yields `rspValid` with `rspTag` equal to the request tag in the cycle after acceptance. A store to 0x10000000 answers with data 0 and no fault, clears speculative status bit 0, and enqueues the low byte of `reqData`.
- R3: A load from 0x10000004 clears speculative status bit 1 and enqueues an entry. It returns the receive byte sign-extended for size code 0 (byte) and zero-extended for size code 2 (word).
- R4: These requests answer with `rspFault` 1 and data 0, enqueue nothing and leave the status unchanged: a load from 0x10000004 with size code 1 or 3, a store to any address other than 0x10000000, and any access to an address outside the three registers.
- R5: A load from 0x10000008 returns the speculative status zero-extended to 32 bits and enqueues nothing. Bit 0 means the transmitter can take a byte and bit 1 means an unread received byte is held.
- R6: When `retireValid` is high with a transmit entry at the head, `txData` takes its byte and `txStart` is 1 for exactly the next cycle. Architectural bit 0 is cleared, and this clear wins over a simultaneous ready edge.
- R7: When `retireValid` is high with a receive entry at the head, architectural bit 1 is cleared, so the next received byte can be captured.
- R8: `rxData` is captured into the receive register, and architectural bit 1 is set, only on a rising edge of `rxDone` while architectural bit 1 is 0. At any other time the byte is ignored.
- R9: A rising edge of `txReady` sets architectural bit 0. A steady high level does nothing more.
- R10: A change of an architectural bit reloads the matching speculative bit one cycle later. A speculative clear by a request accepted in that same cycle takes priority.
- R11: `flush` empties the queue, so a later retire causes no transmit, and loads both speculative bits from the architectural copy. Requests are not accepted while `flush` is high.
- R12: The queue holds 8 entries. While it is full, `reqReady` is 0 and an offered request gets no response and no effect.
- R13: Entries retire in the order they were enqueued. `headValid` and `headTag` show the oldest entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Execute-side request present |
| reqReady | output | 1 | Request will be taken this cycle |
| reqWrite | input | 1 | 1 for store, 0 for load |
| reqAddr | input | 32 | Byte address of the access |
| reqSize | input | 2 | 0 byte, 1 half, 2 word, 3 unsupported |
| reqData | input | 32 | Store data (low byte used) |
| reqTag | input | TAG_W | Reorder-buffer id of the access |
| rspValid | output | 1 | Response present |
| rspData | output | 32 | Load result |
| rspFault | output | 1 | Access was not legal |
| rspTag | output | TAG_W | Tag of the answered access |
| retireValid | input | 1 | Oldest queued entry commits |
| flush | input | 1 | Discard all unretired entries |
| headValid | output | 1 | Queue holds at least one entry |
| headTag | output | TAG_W | Tag of the oldest entry |
| txData | output | 8 | Byte handed to the transmitter |
| txStart | output | 1 | One-cycle transmit start strobe |
| txReady | input | 1 | Transmitter idle |
| rxData | input | 8 | Byte from the receiver |
| rxDone | input | 1 | Receiver has a completed byte |

## Verification
A response appears right after the edge that accepts its request, and the bench samples it 1 ns after that edge. `txStart` and `txData` change on the edge that takes a retire, and the bench samples them 1 ns after that edge and again one cycle later to confirm the strobe lasts a single cycle. An architectural change from a UART edge or a retire reaches the speculative bit on the following edge. Status reads that observe it are therefore issued at least three idle cycles after the stimulus, which covers the edge-detect register, the architectural update and the reload.

// File: rtl/spec_uart_pkg.sv
package spec_uart_pkg;

  localparam logic [1:0] SIZE_BYTE = 2'd0;
  localparam logic [1:0] SIZE_WORD = 2'd2;

  typedef enum logic [1:0] {
    RSP_ZERO,
    RSP_RX_SEXT,
    RSP_RX_ZEXT,
    RSP_STATUS
  } rspSel_e;

  // Strobes from control to datapath, valid in the cycle they are produced
  typedef struct packed {
    logic    push;     // enqueue current request
    logic    pushTx;   // entry being pushed is a transmit entry
    logic    pop;      // head entry retires
    logic    capRx;    // latch receiver byte
    logic    rspLoad;  // register a response
    rspSel_e rspSel;   // response data source
    logic    fault;    // response carries a fault
  } ctrlStb_t;

endpackage

// File: rtl/spec_uart_ctrl.sv
module spec_uart_ctrl
  import spec_uart_pkg::*;
#(
  parameter int          DEPTH   = 8,
  parameter logic [31:0] TX_ADDR = 32'h1000_0000,
  parameter logic [31:0] RX_ADDR = 32'h1000_0004,
  parameter logic [31:0] ST_ADDR = 32'h1000_0008,
  localparam int         PTR_W   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic [31:0]      reqAddr,
  input  logic [1:0]       reqSize,
  input  logic             retireValid,
  input  logic             flush,
  input  logic             headIsTx,
  input  logic             txReady,
  input  logic             rxDone,
  output logic             reqReady,
  output ctrlStb_t         stb,
  output logic [PTR_W-1:0] wrPtr,
  output logic [PTR_W-1:0] rdPtr,
  output logic             headValid,
  output logic [1:0]       specSt
);

  logic [PTR_W:0] count;
  logic [1:0]     archSt;
  logic [1:0]     archNext;
  logic [1:0]     archTog;
  logic [1:0]     seenTog;
  logic           prevTxReady;
  logic           prevRxDone;
  logic           txRise;
  logic           rxRise;
  logic           accept;
  logic           hitTx;
  logic           hitRx;
  logic           hitSt;

  assign reqReady  = (count != DEPTH[PTR_W:0]) && !flush;
  assign headValid = (count != '0);
  assign accept    = reqValid && reqReady;
  assign hitTx     = (reqAddr == TX_ADDR);
  assign hitRx     = (reqAddr == RX_ADDR);
  assign hitSt     = (reqAddr == ST_ADDR);
  assign txRise    = txReady && !prevTxReady;
  assign rxRise    = rxDone && !prevRxDone;

  // Request decode and commit strobes
  always_comb begin
    stb         = '0;
    stb.rspSel  = RSP_ZERO;
    stb.pop     = retireValid && headValid;
    stb.capRx   = rxRise && !archSt[1];
    if (accept) begin
      stb.rspLoad = 1'b1;
      if (reqWrite) begin
        if (hitTx) begin
          stb.push   = 1'b1;
          stb.pushTx = 1'b1;
        end else begin
          stb.fault  = 1'b1;
        end
      end else if (hitRx) begin
        if (reqSize == SIZE_BYTE) begin
          stb.push   = 1'b1;
          stb.rspSel = RSP_RX_SEXT;
        end else if (reqSize == SIZE_WORD) begin
          stb.push   = 1'b1;
          stb.rspSel = RSP_RX_ZEXT;
        end else begin
          stb.fault  = 1'b1;
        end
      end else if (hitSt) begin
        stb.rspSel = RSP_STATUS;
      end else begin
        stb.fault  = 1'b1;
      end
    end
  end

  // Architectural status: UART edges set, retires clear (clear wins)
  always_comb begin
    archNext = archSt;
    if (txRise)    archNext[0] = 1'b1;
    if (stb.capRx) archNext[1] = 1'b1;
    if (stb.pop &&  headIsTx) archNext[0] = 1'b0;
    if (stb.pop && !headIsTx) archNext[1] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      archSt      <= '0;
      archTog     <= '0;
      prevTxReady <= 1'b0;
      prevRxDone  <= 1'b0;
    end else begin
      prevTxReady <= txReady;
      prevRxDone  <= rxDone;
      archSt      <= archNext;
      archTog     <= archTog ^ (archNext ^ archSt);
    end
  end

  // Speculative status: reloaded when a toggle flag differs, cleared by requests
  always_ff @(posedge clk) begin
    if (!rstN) begin
      specSt  <= '0;
      seenTog <= '0;
    end else if (flush) begin
      specSt  <= archSt;
      seenTog <= archTog;
    end else begin
      for (int i = 0; i < 2; i++) begin
        if (seenTog[i] != archTog[i]) begin
          specSt[i]  <= archSt[i];
          seenTog[i] <= archTog[i];
        end
      end
      if (stb.push &&  stb.pushTx) specSt[0] <= 1'b0;
      if (stb.push && !stb.pushTx) specSt[1] <= 1'b0;
    end
  end

  // Queue pointers
  always_ff @(posedge clk) begin
    if (!rstN || flush) begin
      count <= '0;
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (stb.push) wrPtr <= wrPtr + 1'b1;
      if (stb.pop)  rdPtr <= rdPtr + 1'b1;
      if (stb.push && !stb.pop)      count <= count + 1'b1;
      else if (stb.pop && !stb.push) count <= count - 1'b1;
    end
  end

  p_push_room_r12: assert property (@(posedge clk) disable iff (!rstN)
    stb.push |-> (count < DEPTH[PTR_W:0]));

  p_rx_edge_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(archSt[1]) |-> ($past(rxDone) && !$past(prevRxDone)));

  p_tx_edge_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(archSt[0]) |-> $past(txReady));

  p_flush_empty_r11: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> !headValid);

endmodule

// File: rtl/spec_uart_dp.sv
module spec_uart_dp
  import spec_uart_pkg::*;
#(
  parameter int  DEPTH = 8,
  parameter int  TAG_W = 6,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStb_t         stb,
  input  logic [PTR_W-1:0] wrPtr,
  input  logic [PTR_W-1:0] rdPtr,
  input  logic [31:0]      reqData,
  input  logic [TAG_W-1:0] reqTag,
  input  logic [7:0]       rxData,
  input  logic [1:0]       specSt,
  output logic             headIsTx,
  output logic [TAG_W-1:0] headTag,
  output logic             rspValid,
  output logic [31:0]      rspData,
  output logic             rspFault,
  output logic [TAG_W-1:0] rspTag,
  output logic [7:0]       txData,
  output logic             txStart
);

  logic [DEPTH-1:0] qIsTx;
  logic [7:0]       qByte [DEPTH];
  logic [TAG_W-1:0] qTag  [DEPTH];
  logic [7:0]       rxReg;
  logic [31:0]      rspNext;

  assign headIsTx = qIsTx[rdPtr];
  assign headTag  = qTag[rdPtr];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      qIsTx <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        qByte[i] <= '0;
        qTag[i]  <= '0;
      end
    end else if (stb.push) begin
      qIsTx[wrPtr] <= stb.pushTx;
      qByte[wrPtr] <= stb.pushTx ? reqData[7:0] : 8'h00;
      qTag[wrPtr]  <= reqTag;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)          rxReg <= '0;
    else if (stb.capRx) rxReg <= rxData;
  end

  always_comb begin
    unique case (stb.rspSel)
      RSP_RX_SEXT: rspNext = {{24{rxReg[7]}}, rxReg};
      RSP_RX_ZEXT: rspNext = {24'h0, rxReg};
      RSP_STATUS:  rspNext = {30'h0, specSt};
      default:     rspNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspData  <= '0;
      rspFault <= 1'b0;
      rspTag   <= '0;
    end else begin
      rspValid <= stb.rspLoad;
      rspData  <= stb.rspLoad ? rspNext : 32'h0;
      rspFault <= stb.rspLoad && stb.fault;
      rspTag   <= reqTag;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txData  <= '0;
      txStart <= 1'b0;
    end else begin
      txStart <= 1'b0;
      if (stb.pop && headIsTx) begin
        txData  <= qByte[rdPtr];
        txStart <= 1'b1;
      end
    end
  end

  p_tx_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    txStart |=> !txStart);

  p_fault_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    rspFault |-> (rspValid && rspData == 32'h0));

endmodule

// File: rtl/spec_uart_regs.sv
module spec_uart_regs
  import spec_uart_pkg::*;
#(
  parameter int          DEPTH   = 8,
  parameter int          TAG_W   = 6,
  parameter logic [31:0] TX_ADDR = 32'h1000_0000,
  parameter logic [31:0] RX_ADDR = 32'h1000_0004,
  parameter logic [31:0] ST_ADDR = 32'h1000_0008
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic             reqWrite,
  input  logic [31:0]      reqAddr,
  input  logic [1:0]       reqSize,
  input  logic [31:0]      reqData,
  input  logic [TAG_W-1:0] reqTag,
  output logic             rspValid,
  output logic [31:0]      rspData,
  output logic             rspFault,
  output logic [TAG_W-1:0] rspTag,
  input  logic             retireValid,
  input  logic             flush,
  output logic             headValid,
  output logic [TAG_W-1:0] headTag,
  output logic [7:0]       txData,
  output logic             txStart,
  input  logic             txReady,
  input  logic [7:0]       rxData,
  input  logic             rxDone
);

  localparam int PTR_W = $clog2(DEPTH);

  ctrlStb_t         stb;
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;
  logic [1:0]       specSt;
  logic             headIsTx;

  spec_uart_ctrl #(
    .DEPTH(DEPTH), .TX_ADDR(TX_ADDR), .RX_ADDR(RX_ADDR), .ST_ADDR(ST_ADDR)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqSize(reqSize), .retireValid(retireValid),
    .flush(flush), .headIsTx(headIsTx), .txReady(txReady), .rxDone(rxDone),
    .reqReady(reqReady), .stb(stb), .wrPtr(wrPtr), .rdPtr(rdPtr),
    .headValid(headValid), .specSt(specSt)
  );

  spec_uart_dp #(.DEPTH(DEPTH), .TAG_W(TAG_W)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrPtr(wrPtr), .rdPtr(rdPtr),
    .reqData(reqData), .reqTag(reqTag), .rxData(rxData), .specSt(specSt),
    .headIsTx(headIsTx), .headTag(headTag), .rspValid(rspValid),
    .rspData(rspData), .rspFault(rspFault), .rspTag(rspTag),
    .txData(txData), .txStart(txStart)
  );

endmodule

// File: tb/spec_uart_regs_test.sv
`timescale 1ns/1ps
module spec_uart_regs_test;

  localparam logic [31:0] A_TX = 32'h1000_0000;
  localparam logic [31:0] A_RX = 32'h1000_0004;
  localparam logic [31:0] A_ST = 32'h1000_0008;

  typedef struct packed {
    logic        wr;
    logic [31:0] addr;
    logic [1:0]  size;
    logic [7:0]  data;
    logic [31:0] expData;
    logic        expFault;
  } vec_t;

  // Applied with rx byte 0x85 held and both status bits set
  localparam vec_t VECS [8] = '{
    '{1'b0, A_RX, 2'd0, 8'h00, 32'hFFFF_FF85, 1'b0},  // R3 byte sign-extend
    '{1'b0, A_RX, 2'd2, 8'h00, 32'h0000_0085, 1'b0},  // R3 word zero-extend
    '{1'b0, A_RX, 2'd1, 8'h00, 32'h0000_0000, 1'b1},  // R4 half faults
    '{1'b0, A_RX, 2'd3, 8'h00, 32'h0000_0000, 1'b1},  // R4 size 3 faults
    '{1'b0, A_ST, 2'd2, 8'h00, 32'h0000_0001, 1'b0},  // R5 status, rx bit cleared
    '{1'b1, A_ST, 2'd2, 8'h77, 32'h0000_0000, 1'b1},  // R4 store to status
    '{1'b0, 32'h1000_000C, 2'd2, 8'h00, 32'h0, 1'b1}, // R4 unknown address
    '{1'b1, A_TX, 2'd0, 8'h5A, 32'h0000_0000, 1'b0}   // R2 transmit store
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic        reqWrite = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [1:0]  reqSize = '0;
  logic [31:0] reqData = '0;
  logic [5:0]  reqTag = '0;
  logic        rspValid;
  logic [31:0] rspData;
  logic        rspFault;
  logic [5:0]  rspTag;
  logic        retireValid = 1'b0;
  logic        flush = 1'b0;
  logic        headValid;
  logic [5:0]  headTag;
  logic [7:0]  txData;
  logic        txStart;
  logic        txReady = 1'b0;
  logic [7:0]  rxData = '0;
  logic        rxDone = 1'b0;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  spec_uart_regs uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqSize(reqSize),
    .reqData(reqData), .reqTag(reqTag), .rspValid(rspValid),
    .rspData(rspData), .rspFault(rspFault), .rspTag(rspTag),
    .retireValid(retireValid), .flush(flush), .headValid(headValid),
    .headTag(headTag), .txData(txData), .txStart(txStart),
    .txReady(txReady), .rxData(rxData), .rxDone(rxDone)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic doReq(input logic wr, input logic [31:0] addr, input logic [1:0] size,
                       input logic [7:0] data, input logic [5:0] tag,
                       output logic v, output logic [31:0] d, output logic f, output logic [5:0] t);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = addr; reqSize = size;
    reqData = {24'h0, data}; reqTag = tag;
    @(posedge clk); #1;
    v = rspValid; d = rspData; f = rspFault; t = rspTag;
    reqValid = 1'b0;
  endtask

  task automatic statusIs(input string req, input logic [31:0] exp);
    logic v, f; logic [31:0] d; logic [5:0] t;
    doReq(1'b0, A_ST, 2'd2, 8'h00, 6'd63, v, d, f, t);
    chk(req, {v, f, d[29:0]}, {1'b1, 1'b0, exp[29:0]});
  endtask

  task automatic retireOne;
    @(negedge clk); retireValid = 1'b1;
    @(posedge clk); #1;
    retireValid = 1'b0;
  endtask

  task automatic rxPulse(input logic [7:0] b);
    @(negedge clk); rxData = b; rxDone = 1'b1;
    @(negedge clk); rxDone = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic v, f; logic [31:0] d; logic [5:0] t;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    #1;
    // R1 reset state
    chk("R1 outputs", {31'h0, reqReady}, 32'h1);
    chk("R1 idle", {29'h0, rspValid, txStart, headValid}, 32'h0);
    statusIs("R1 R5 status after reset", 32'h0);

    // R9 R10 transmitter ready edge
    @(negedge clk); txReady = 1'b1;
    idle(3);
    statusIs("R9 R10 tx ready rise", 32'h1);

    // R8 R10 byte capture
    rxPulse(8'h85);
    idle(3);
    statusIs("R8 R10 rx byte held", 32'h3);

    // vector table
    for (int i = 0; i < 8; i++) begin
      doReq(VECS[i].wr, VECS[i].addr, VECS[i].size, VECS[i].data, 6'(i + 1), v, d, f, t);
      chk($sformatf("R2 vec%0d valid/tag", i), {25'h0, v, t}, {25'h0, 1'b1, 6'(i + 1)});
      chk($sformatf("R3 R4 vec%0d data", i), d, VECS[i].expData);
      chk($sformatf("R4 vec%0d fault", i), {31'h0, f}, {31'h0, VECS[i].expFault});
    end
    statusIs("R2 R3 speculative clears", 32'h0);
    chk("R13 head is oldest", {25'h0, headValid, headTag}, {25'h0, 1'b1, 6'd1});

    // R11 flush
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    #1;
    chk("R11 queue empty", {31'h0, headValid}, 32'h0);
    idle(1);
    statusIs("R11 spec reloaded", 32'h3);
    retireOne();
    chk("R11 no tx after flush", {31'h0, txStart}, 32'h0);
    idle(1);
    chk("R11 no tx later", {31'h0, txStart}, 32'h0);

    // R7 R8 receive commit
    doReq(1'b0, A_RX, 2'd0, 8'h00, 6'd9, v, d, f, t);
    chk("R3 rx byte again", d, 32'hFFFF_FF85);
    rxPulse(8'h11);
    idle(2);
    doReq(1'b0, A_RX, 2'd2, 8'h00, 6'd10, v, d, f, t);
    chk("R8 byte ignored while held", d, 32'h85);
    retireOne();
    idle(3);
    statusIs("R7 rx retired", 32'h1);
    retireOne();
    rxPulse(8'h22);
    idle(2);
    doReq(1'b0, A_RX, 2'd2, 8'h00, 6'd11, v, d, f, t);
    chk("R7 R8 new byte captured", d, 32'h22);
    retireOne();
    idle(2);

    // R6 transmit commit
    doReq(1'b1, A_TX, 2'd0, 8'hC3, 6'd12, v, d, f, t);
    retireOne();
    chk("R6 start strobe", {23'h0, txStart, txData}, {23'h0, 1'b1, 8'hC3});
    idle(1);
    chk("R6 strobe one cycle", {31'h0, txStart}, 32'h0);
    idle(3);
    statusIs("R6 arch tx cleared", 32'h0);
    idle(3);
    statusIs("R9 level does not set", 32'h0);
    @(negedge clk); txReady = 1'b0;
    @(negedge clk); txReady = 1'b1;
    idle(3);
    statusIs("R9 rise sets ready", 32'h1);

    // R12 R13 fill and drain
    for (int i = 0; i < 8; i++)
      doReq(1'b1, A_TX, 2'd0, 8'(8'h10 + i), 6'(20 + i), v, d, f, t);
    #1;
    chk("R12 full not ready", {31'h0, reqReady}, 32'h0);
    doReq(1'b1, A_TX, 2'd0, 8'hEE, 6'd40, v, d, f, t);
    chk("R12 refused no response", {31'h0, v}, 32'h0);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk($sformatf("R13 head tag %0d", i), {26'h0, headTag}, {26'h0, 6'(20 + i)});
      retireOne();
      chk($sformatf("R13 R6 order %0d", i), {23'h0, txStart, txData}, {23'h0, 1'b1, 8'(8'h10 + i)});
    end
    #1;
    chk("R12 drained", {30'h0, headValid, reqReady}, 32'h1);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule